// File: doc/BRIEF.md
# Event Timer and Watchdog with Shared Prescaler

This block puts an event timer and a watchdog side by side and lets them share one prescaler. The timer is `TMR_W` bits wide, 8 by default. It counts either instruction ticks or edges on an external pin. An instruction tick is the core clock divided by 2 or by 4. The pin passes through a synchronizer, and a control bit chooses whether its rising or its falling edge counts. When the timer wraps from all ones to zero, it raises a sticky interrupt flag.

The watchdog counts pulses on its own tick input. The tick input stands in for a free-running RC oscillator, so the watchdog keeps counting while the core is asleep. When the watchdog is enabled and its counter wraps, it emits a reset pulse one cycle wide.

One 8-bit prescaler serves both counters. A control bit hands it to the timer or to the watchdog. The counter that does not hold it runs undivided. Software writes a 7-bit control word and can load the timer value directly. The watchdog is serviced through a clear input.

Top module: `cwd_top`

## Requirements
- R1: After reset, `cnt_q` is 0 and `irq_flag` and `wdg_rst` are low. The control word is all zeros, which means internal source, rising edge, prescaler on the timer with ratio 2, and watchdog disabled.
- R2: With the internal source selected, an instruction tick occurs every 2 clocks when `cfg_div4`=0 and every 4 clocks when `cfg_div4`=1. Without the prescaler, the timer adds 1 on each instruction tick.
- R3: The prescaler select field `s` (control bits 5:3) gives a division ratio of 2^(s+1) to the counter that owns the prescaler. Ownership is set by control bit 2: 0 gives it to the timer, 1 to the watchdog. The counter that does not own it counts every source event.
- R4: With external source selected (control bit 0 = 1), the timer counts rising edges of `ext_pin` when control bit 1 = 0 and falling edges when it is 1. The pin is synchronized in two flops. A pin change driven before clock edge k shows up in `cnt_q` after edge k+2.
- R5: A pulse on `cnt_wr` loads `cnt_wdata` into the timer at the next edge. The load takes priority over a count and clears the prescaler.
- R6: When the timer wraps from all ones to zero, `irq_flag` goes high in the same cycle that `cnt_q` shows 0. The flag stays high until `irq_clr`. If a set and a clear arrive together, the set wins.
- R7: While `sleep` is high, the timer holds its value. The watchdog and its tick input keep working during sleep.
- R8: With the watchdog enabled (control bit 6 = 1), `wdg_rst` pulses high for exactly one cycle when the watchdog counter wraps. The wrap comes after 2^WDG_W watchdog increments since the last clear.
- R9: While the watchdog is disabled, its counter is held at zero and `wdg_rst` stays low.
- R10: A pulse on `wdg_clr` zeroes the watchdog counter and the prescaler. The timeout count then starts again from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_div4 | input | 1 | Instruction tick divider: 0 gives clk/2, 1 gives clk/4 |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 7 | Control word: [0] external source, [1] falling edge, [2] prescaler to watchdog, [5:3] prescaler select, [6] watchdog enable |
| cnt_wr | input | 1 | Write strobe for the timer value |
| cnt_wdata | input | TMR_W | Timer load value |
| cnt_q | output | TMR_W | Current timer value |
| ext_pin | input | 1 | External count input, asynchronous |
| irq_clr | input | 1 | Clears the overflow flag |
| irq_flag | output | 1 | Sticky timer overflow flag |
| wdg_tick | input | 1 | Watchdog oscillator tick, one clock wide per event |
| wdg_clr | input | 1 | Watchdog service: clears the watchdog counter and the prescaler |
| sleep | input | 1 | Sleep mode: stops the timer source |
| wdg_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench builds the block with `TMR_W`=8 and `WDG_W`=4. The 4-bit watchdog reaches its timeout after 16 increments. That makes every prescaler setting, up to a ratio of 256 and 4096 cycles, short enough to sweep exhaustively. The bench sweeps the timer increment period over both instruction dividers and all nine prescaler routings. It also sweeps the watchdog timeout over all nine routings. The external pin is driven with counted pulse trains on both edge polarities, with and without division, and the synchronizer latency is checked to the exact cycle.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  localparam int PSEL_W = 3;
  localparam int PRE_W  = 1 << PSEL_W;
  localparam int CTL_W  = PSEL_W + 4;

  typedef struct packed {
    logic              wdg_en;
    logic [PSEL_W-1:0] pre_sel;
    logic              pre_wdg;
    logic              fall_edge;
    logic              ext_src;
  } ctl_t;

  localparam ctl_t CTL_RST = '0;
endpackage

// File: rtl/cwd_src.sv
module cwd_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div4,
  input  logic sleep,
  input  logic ext_sel,
  input  logic fall_sel,
  input  logic pin,
  output logic src_tick
);
  logic [1:0]             ph_q, ph_d;
  logic [SYNC_STAGES-1:0] sy_q, sy_d;
  logic                   last_q;
  logic                   itick, edge_hit, pin_s;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      assign sy_d = pin;
    end else begin : g_syncn
      assign sy_d = {sy_q[SYNC_STAGES-2:0], pin};
    end
  endgenerate

  assign pin_s = sy_q[SYNC_STAGES-1];

  always_comb begin
    itick = !sleep && (ph_q >= (div4 ? 2'd3 : 2'd1));
    if (sleep)      ph_d = ph_q;
    else if (itick) ph_d = '0;
    else            ph_d = ph_q + 2'd1;
    edge_hit = fall_sel ? (!pin_s && last_q) : (pin_s && !last_q);
    src_tick = ext_sel ? (edge_hit && !sleep) : itick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sy_q   <= '0;
      last_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sy_q   <= sy_d;
      last_q <= pin_s;
    end
  end

  // R2
  itick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    itick |=> !itick);
endmodule

// File: rtl/cwd_presc.sv
module cwd_presc #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tap
);
  localparam int CW = 1 << SEL_W;

  logic [CW-1:0] cnt_q, cnt_d, mask;

  generate
    for (genvar i = 0; i < CW; i++) begin : g_mask
      assign mask[i] = (sel >= (SEL_W)'(i));
    end
  endgenerate

  always_comb begin
    tap = src && ((cnt_q & mask) == mask);
    if (clr)      cnt_d = '0;
    else if (src) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10
  clr_no_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tap);
endmodule

// File: rtl/cwd_tmr.sv
module cwd_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         inc,
  input  logic         irq_clr,
  output logic [W-1:0] cnt_q,
  output logic         irq_q
);
  logic [W-1:0] cnt_d;
  logic         irq_d, ovf;

  always_comb begin
    ovf = inc && !wr && (&cnt_q);
    if (wr)       cnt_d = wr_data;
    else if (inc) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
    if (ovf)          irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
    else              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  // R5
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt_q == $past(wr_data));
  // R6
  wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && $past(&cnt_q) && !$past(wr)) |-> irq_q);
endmodule

// File: rtl/cwd_wdg.sv
module cwd_wdg #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic inc,
  input  logic clr,
  output logic rst_q
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         fire;

  always_comb begin
    fire = en && !clr && inc && (&cnt_q);
    if (!en || clr) cnt_d = '0;
    else if (inc)   cnt_d = cnt_q + 1'b1;
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= fire;
    end
  end

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rst_q);
  // R10
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rst_q);
endmodule

// File: rtl/cwd_top.sv
module cwd_top
  import cwd_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int WDG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_div4,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cnt_wr,
  input  logic [TMR_W-1:0] cnt_wdata,
  output logic [TMR_W-1:0] cnt_q,
  input  logic             ext_pin,
  input  logic             irq_clr,
  output logic             irq_flag,
  input  logic             wdg_tick,
  input  logic             wdg_clr,
  input  logic             sleep,
  output logic             wdg_rst
);
  logic [1:0] rs_q;
  logic       rst_i;
  ctl_t       ctl_q, ctl_d;
  logic       tmr_src, pre_src, pre_clr, pre_tap, tmr_inc, wdg_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_comb begin
    ctl_d   = ctl_wr ? ctl_t'(ctl_wdata) : ctl_q;
    pre_src = ctl_q.pre_wdg ? wdg_tick : tmr_src;
    pre_clr = cnt_wr || wdg_clr;
    tmr_inc = ctl_q.pre_wdg ? tmr_src  : pre_tap;
    wdg_inc = ctl_q.pre_wdg ? pre_tap  : wdg_tick;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_d;
  end

  cwd_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_i), .div4(cfg_div4), .sleep(sleep),
    .ext_sel(ctl_q.ext_src), .fall_sel(ctl_q.fall_edge), .pin(ext_pin),
    .src_tick(tmr_src)
  );

  cwd_presc #(.SEL_W(PSEL_W)) u_presc (
    .clk(clk), .rst_n(rst_i), .src(pre_src), .clr(pre_clr),
    .sel(ctl_q.pre_sel), .tap(pre_tap)
  );

  cwd_tmr #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_i), .wr(cnt_wr), .wr_data(cnt_wdata),
    .inc(tmr_inc), .irq_clr(irq_clr), .cnt_q(cnt_q), .irq_q(irq_flag)
  );

  cwd_wdg #(.W(WDG_W)) u_wdg (
    .clk(clk), .rst_n(rst_i), .en(ctl_q.wdg_en), .inc(wdg_inc),
    .clr(wdg_clr), .rst_q(wdg_rst)
  );

  // R7
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (sleep && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: tb/cwd_top_test.sv
module cwd_top_test;
  logic       clk = 0;
  logic       rst_n, cfg_div4, ctl_wr, cnt_wr, ext_pin, irq_clr;
  logic       wdg_tick, wdg_clr, sleep;
  logic [6:0] ctl_wdata;
  logic [7:0] cnt_wdata, cnt_q;
  logic       irq_flag, wdg_rst;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  cwd_top #(.TMR_W(8), .WDG_W(4), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_div4(cfg_div4), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_q(cnt_q), .ext_pin(ext_pin), .irq_clr(irq_clr),
    .irq_flag(irq_flag), .wdg_tick(wdg_tick), .wdg_clr(wdg_clr),
    .sleep(sleep), .wdg_rst(wdg_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ctl(input bit en, input int sel, input bit pw, input bit fall, input bit ext);
    @(negedge clk);
    ctl_wdata = {en, 3'(sel < 0 ? 0 : sel), pw, fall, ext};
    ctl_wr = 1;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk);
    cnt_wdata = v; cnt_wr = 1;
    @(negedge clk);
    cnt_wr = 0;
  endtask

  // cycles between two successive timer changes, plus the step size
  task automatic measure(output int per, output int step);
    logic [7:0] p;
    int lim;
    p = cnt_q; lim = 0;
    while (cnt_q == p && lim < 3000) begin @(negedge clk); lim++; end
    p = cnt_q; per = 0;
    while (cnt_q == p && per < 3000) begin @(negedge clk); per++; end
    step = int'(cnt_q) - int'(p);
    if (step < 0) step += 256;
  endtask

  // clear watchdog with tick held high, count cycles to the reset pulse
  task automatic wdg_wait(output int n);
    @(negedge clk);
    wdg_tick = 1; wdg_clr = 1;
    @(negedge clk);
    wdg_clr = 0; n = 0;
    while (n < 10000) begin
      @(negedge clk); n++;
      if (wdg_rst) break;
    end
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      ext_pin = 1; repeat (4) @(negedge clk);
      ext_pin = 0; repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int per, step, n, exp, r;
    logic [7:0] hold;
    rst_n = 0; cfg_div4 = 0; ctl_wr = 0; cnt_wr = 0; ext_pin = 0; irq_clr = 0;
    wdg_tick = 0; wdg_clr = 0; sleep = 0; ctl_wdata = '0; cnt_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    chk(cnt_q == 0, "R1 cnt", cnt_q, 0);
    chk(!irq_flag, "R1 irq", irq_flag, 0);
    chk(!wdg_rst, "R1 wdg_rst", wdg_rst, 0);
    // R1 default control: prescaler on timer, ratio 2, div 2
    measure(per, step);
    chk(per == 4, "R1 default period", per, 4);

    // R2 / R3 timer period sweep
    for (int d = 0; d < 2; d++) begin
      for (int s = -1; s < 8; s++) begin
        cfg_div4 = d[0];
        set_ctl(0, s, s < 0, 0, 0);
        r = (s < 0) ? 1 : (2 << s);
        exp = (d ? 4 : 2) * r;
        measure(per, step);
        chk(per == exp, (s < 0) ? "R2 period" : "R3 period", per, exp);
        chk(step == 1, "R2 step", step, 1);
      end
    end
    cfg_div4 = 0;

    // R5 load
    set_ctl(0, 0, 1, 0, 0);
    @(negedge clk);
    cnt_wdata = 8'hFD; cnt_wr = 1; irq_clr = 1;
    @(negedge clk);
    cnt_wr = 0; irq_clr = 0;
    chk(cnt_q == 8'hFD, "R5 load", cnt_q, 8'hFD);
    chk(!irq_flag, "R6 cleared", irq_flag, 0);
    // R6 overflow sets flag together with zero
    n = 0;
    while (cnt_q != 0 && n < 50) begin
      chk(!irq_flag, "R6 early", irq_flag, 0);
      @(negedge clk); n++;
    end
    chk(cnt_q == 0 && irq_flag, "R6 wrap", irq_flag, 1);
    repeat (10) @(negedge clk);
    chk(irq_flag, "R6 sticky", irq_flag, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(!irq_flag, "R6 clear", irq_flag, 0);

    // R7 timer holds in sleep
    sleep = 1;
    @(negedge clk); hold = cnt_q;
    repeat (40) @(negedge clk);
    chk(cnt_q == hold, "R7 hold", cnt_q, hold);
    sleep = 0;

    // R4 external edges
    set_ctl(0, 0, 1, 0, 1);
    load(0);
    pulses(6); repeat (4) @(negedge clk);
    chk(cnt_q == 6, "R4 rising", cnt_q, 6);
    set_ctl(0, 0, 1, 1, 1);
    load(0);
    pulses(5); repeat (4) @(negedge clk);
    chk(cnt_q == 5, "R4 falling", cnt_q, 5);
    // R3 prescaled external
    set_ctl(0, 1, 0, 0, 1);
    load(0);
    pulses(8); repeat (4) @(negedge clk);
    chk(cnt_q == 2, "R3 ext div4", cnt_q, 2);
    set_ctl(0, 2, 0, 0, 1);
    load(0);
    pulses(12); repeat (4) @(negedge clk);
    chk(cnt_q == 1, "R3 ext div8", cnt_q, 1);
    // R4 latency: change visible after third edge
    set_ctl(0, 0, 1, 0, 1);
    load(0);
    repeat (2) @(negedge clk);
    ext_pin = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(cnt_q == 0, "R4 latency early", cnt_q, 0);
    @(posedge clk); @(negedge clk);
    chk(cnt_q == 1, "R4 latency", cnt_q, 1);
    ext_pin = 0;
    set_ctl(0, 0, 1, 0, 0);

    // R8 / R3 watchdog timeout sweep
    for (int s = -1; s < 8; s++) begin
      set_ctl(1, s, s >= 0, 0, 0);
      exp = 16 * ((s < 0) ? 1 : (2 << s));
      wdg_wait(n);
      chk(n == exp, (s < 0) ? "R8 timeout" : "R3 wdg timeout", n, exp);
      @(negedge clk);
      chk(!wdg_rst, "R8 width", wdg_rst, 0);
    end

    // R10 clear midway restarts count
    set_ctl(1, 0, 0, 0, 0);
    wdg_wait(n);
    @(negedge clk); wdg_clr = 1; @(negedge clk); wdg_clr = 0;
    repeat (10) @(negedge clk);
    wdg_wait(n);
    chk(n == 16, "R10 restart", n, 16);

    // R7 watchdog still counts in sleep
    sleep = 1;
    wdg_wait(n);
    chk(n == 16, "R7 wdg sleep", n, 16);
    sleep = 0;

    // R9 disabled watchdog stays quiet
    set_ctl(0, 0, 0, 0, 0);
    n = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (wdg_rst) n++; end
    chk(n == 0, "R9 disabled", n, 0);
    wdg_tick = 0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule